// File: doc/BRIEF.md
# BCD Real-Time Clock Calendar

This block keeps the time of day and the calendar date, with every field held in packed binary coded decimal. A one-cycle enable pulse arrives for each period of a 32.768 kHz time base. A fractional divider turns those pulses into an exact 100 Hz step. That step drives a carry chain through hundredths of a second, seconds, minutes, 24-hour hours, weekday, day of month, month and a two-digit year. A century flag toggles each time the year wraps.

A host sets the time by writing single bytes through a small write port. The whole eight-byte register file is always visible as one flat 64-bit read bus, with byte k at bits 8k+7..8k. Month lengths, including February in leap years, are applied automatically. The leap rule is "year divisible by four", so it holds up to the year 2099.

Top module: `rtc_bcd_calendar`

## Requirements
- R1: After reset the view reads hundredths 00, seconds 00, minutes 00, hours 00 with the century bit clear, weekday 01, date 01, month 01 and year 00, i.e. 64'h00_01_01_01_00_00_00_00.
- R2: Each stored BCD digit stays in 0..9. Seconds and minutes stay at 59 or below, hours at 23 or below, weekday in 1..7, date in 1..31 and month in 1..12, provided the host writes legal values.
- R3: The hundredths field advances only on a time-base pulse, using a divider that adds 100 per pulse and wraps at 32768. After the divider is cleared, the first advance happens on the 328th pulse, and exactly 100 advances happen in 32768 pulses.
- R4: Hundredths wrap 99 to 00 into seconds, seconds 59 to 00 into minutes, minutes 59 to 00 into hours, and hours 23 to 00 into the date.
- R5: On each hour wrap the weekday advances, and it wraps from 07 to 01.
- R6: The date wraps to 01 after day 30 in months 04, 06, 09 and 11, and after day 31 in the other months except February. On a date wrap the month advances, and month 12 wraps to 01 with a year increment.
- R7: February ends on day 29 when the year value is divisible by four (including 00), and on day 28 otherwise.
- R8: Bit 7 of the hours byte (address 3) is a century flag that inverts when the year wraps from 99 to 00. Bit 6 of that byte always reads 0.
- R9: A write loads byte address wr_addr. The addresses are 0 hundredths, 1 seconds, 2 minutes, 3 hours, 4 weekday, 5 date, 6 month and 7 year. Bits that a field does not use are discarded and read as 0: bit 7 of seconds and minutes, bit 6 of hours, bits 7..3 of weekday, bits 7..6 of date, and bits 7..5 of month. Other bytes are unchanged.
- R10: A write to the hundredths byte also clears the divider, restarting the 328-pulse wait to the next advance.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_32k | input | 1 | One-cycle enable per 32.768 kHz period |
| wr_en | input | 1 | Host byte write strobe |
| wr_addr | input | 3 | Register byte address |
| wr_data | input | 8 | Byte to write |
| time_view | output | 64 | All eight registers, byte k at bits 8k+7..8k |

## Verification
The range and digit properties assume the host only writes legal BCD values within each field's range. The bench keeps to this by loading only real calendar times. The carry properties assume that no write lands in the same cycle as a divider step. The bench guarantees this by never asserting tick_32k while a write is in flight, and the properties are also disabled when wr_en is high. The table vectors place each clock just before a rollover, so that a single hundredth step has to ripple through the whole chain.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int unsigned NREG = 8;

  typedef enum logic [2:0] {
    REG_HSEC = 3'd0, REG_SEC = 3'd1, REG_MIN = 3'd2, REG_HOUR = 3'd3,
    REG_DOW = 3'd4, REG_DATE = 3'd5, REG_MONTH = 3'd6, REG_YEAR = 3'd7
  } rtc_reg_e;

  // increment a two-digit BCD value (no range wrap)
  function automatic logic [7:0] bcd_inc(logic [7:0] v);
    if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
    return {v[7:4], v[3:0] + 4'd1};
  endfunction

  function automatic logic leap_year(logic [7:0] yr);
    logic [6:0] b;
    b = {3'b000, yr[7:4]} * 7'd10 + {3'b000, yr[3:0]};
    return b[1:0] == 2'b00;
  endfunction

  function automatic logic [7:0] month_last_day(logic [7:0] mon, logic [7:0] yr);
    case (mon)
      8'h02: return leap_year(yr) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default: return 8'h31;
    endcase
  endfunction

  function automatic logic [7:0] reg_mask(logic [2:0] idx);
    case (rtc_reg_e'(idx))
      REG_SEC, REG_MIN: return 8'h7F;
      REG_HOUR:         return 8'hBF;
      REG_DOW:          return 8'h07;
      REG_DATE:         return 8'h3F;
      REG_MONTH:        return 8'h1F;
      default:          return 8'hFF;
    endcase
  endfunction

  function automatic logic [7:0] reg_reset(logic [2:0] idx);
    case (rtc_reg_e'(idx))
      REG_DOW, REG_DATE, REG_MONTH: return 8'h01;
      default: return 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/rtc_tick_divider.sv
module rtc_tick_divider #(
  parameter int unsigned BASE_HZ = 32768,
  parameter int unsigned OUT_HZ  = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_in,
  input  logic clr,
  output logic step
);
  localparam int unsigned AW = $clog2(BASE_HZ + OUT_HZ) + 1;

  logic [AW-1:0] acc;
  logic [AW-1:0] sum;

  assign sum  = acc + AW'(OUT_HZ);
  assign step = tick_in && (sum >= AW'(BASE_HZ));

  always_ff @(posedge clk) begin
    if (!rst_n || clr) acc <= '0;
    else if (tick_in)  acc <= step ? sum - AW'(BASE_HZ) : sum;
  end
endmodule

// File: rtl/rtc_calendar_core.sv
module rtc_calendar_core
  import rtc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       step,
  input  logic       wr_en,
  input  logic [2:0] wr_addr,
  input  logic [7:0] wr_data,
  output logic [63:0] view,
  output logic       adv_min,
  output logic       adv_day,
  output logic       adv_month,
  output logic       adv_cent
);
  logic [7:0] f   [NREG];
  logic [7:0] nxt [NREG];
  logic adv_sec, adv_hour, adv_year;
  logic [7:0] hour_inc;

  assign adv_sec   = step && f[REG_HSEC] == 8'h99;
  assign adv_min   = adv_sec && f[REG_SEC] == 8'h59;
  assign adv_hour  = adv_min && f[REG_MIN] == 8'h59;
  assign adv_day   = adv_hour && f[REG_HOUR][5:0] == 6'h23;
  assign adv_month = adv_day && f[REG_DATE] == month_last_day(f[REG_MONTH], f[REG_YEAR]);
  assign adv_year  = adv_month && f[REG_MONTH] == 8'h12;
  assign adv_cent  = adv_year && f[REG_YEAR] == 8'h99;
  assign hour_inc  = bcd_inc({2'b00, f[REG_HOUR][5:0]});

  always_comb begin
    nxt = f;
    if (step)     nxt[REG_HSEC]  = adv_sec ? 8'h00 : bcd_inc(f[REG_HSEC]);
    if (adv_sec)  nxt[REG_SEC]   = adv_min ? 8'h00 : bcd_inc(f[REG_SEC]);
    if (adv_min)  nxt[REG_MIN]   = adv_hour ? 8'h00 : bcd_inc(f[REG_MIN]);
    if (adv_hour) nxt[REG_HOUR]  = {f[REG_HOUR][7], 1'b0, adv_day ? 6'h00 : hour_inc[5:0]};
    if (adv_day) begin
      nxt[REG_DOW]  = (f[REG_DOW] == 8'h07) ? 8'h01 : bcd_inc(f[REG_DOW]);
      nxt[REG_DATE] = adv_month ? 8'h01 : bcd_inc(f[REG_DATE]);
    end
    if (adv_month) nxt[REG_MONTH] = adv_year ? 8'h01 : bcd_inc(f[REG_MONTH]);
    if (adv_year)  nxt[REG_YEAR]  = adv_cent ? 8'h00 : bcd_inc(f[REG_YEAR]);
    if (adv_cent)  nxt[REG_HOUR][7] = ~f[REG_HOUR][7];
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < NREG; i++) begin
      if (!rst_n)
        f[i] <= reg_reset(3'(i));
      else if (wr_en && wr_addr == 3'(i))
        f[i] <= wr_data & reg_mask(3'(i));
      else
        f[i] <= nxt[i];
    end
  end

  for (genvar g = 0; g < NREG; g++) begin : g_view
    assign view[8*g +: 8] = f[g];
  end
endmodule

// File: rtl/rtc_bcd_calendar.sv
module rtc_bcd_calendar #(
  parameter int unsigned BASE_HZ = 32768,
  parameter int unsigned OUT_HZ  = 100
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick_32k,
  input  logic        wr_en,
  input  logic [2:0]  wr_addr,
  input  logic [7:0]  wr_data,
  output logic [63:0] time_view
);
  logic hit_100;
  logic clr_div;
  logic adv_min, adv_day, adv_month, adv_cent;

  assign clr_div = wr_en && wr_addr == 3'd0;

  rtc_tick_divider #(.BASE_HZ(BASE_HZ), .OUT_HZ(OUT_HZ)) u_div (
    .clk(clk), .rst_n(rst_n), .tick_in(tick_32k), .clr(clr_div), .step(hit_100)
  );

  rtc_calendar_core u_core (
    .clk(clk), .rst_n(rst_n), .step(hit_100),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .view(time_view), .adv_min(adv_min), .adv_day(adv_day),
    .adv_month(adv_month), .adv_cent(adv_cent)
  );
endmodule

// File: rtl/rtc_bcd_calendar_chk.sv
module rtc_bcd_calendar_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        tick_32k,
  input logic        wr_en,
  input logic [2:0]  wr_addr,
  input logic [7:0]  wr_data,
  input logic [63:0] time_view,
  input logic        hit_100,
  input logic        adv_min,
  input logic        adv_day,
  input logic        adv_month,
  input logic        adv_cent
);
  logic [7:0] hs, sc, mn, hr, dw, dt, mo, yr;
  assign {yr, mo, dt, dw, hr, mn, sc, hs} = time_view;

  assert_bcd_digits_R2: assert property (@(posedge clk) disable iff (!rst_n)
    hs[3:0] <= 4'd9 && sc[3:0] <= 4'd9 && mn[3:0] <= 4'd9 && hr[3:0] <= 4'd9 &&
    dt[3:0] <= 4'd9 && mo[3:0] <= 4'd9 && yr[3:0] <= 4'd9 && yr[7:4] <= 4'd9 &&
    hs[7:4] <= 4'd9);

  assert_ranges_R2: assert property (@(posedge clk) disable iff (!rst_n)
    sc <= 8'h59 && mn <= 8'h59 && hr[5:0] <= 6'h23 && hr[6] == 1'b0 &&
    dw >= 8'h01 && dw <= 8'h07 && dt >= 8'h01 && dt <= 8'h31 &&
    mo >= 8'h01 && mo <= 8'h12);

  assert_idle_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_32k && !wr_en) |=> $stable(time_view));

  assert_step_needs_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
    hit_100 |-> tick_32k);

  assert_min_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_min && !wr_en) |=> (sc == 8'h00 && hs == 8'h00));

  assert_day_roll_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_day && !wr_en) |=> (hr[5:0] == 6'h00 &&
      dw == (($past(dw) == 8'h07) ? 8'h01 : $past(dw) + 8'h01)));

  assert_month_roll_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_month && !wr_en) |=> (dt == 8'h01 && mo != $past(mo)));

  assert_century_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_cent && !wr_en) |=> (hr[7] != $past(hr[7]) && yr == 8'h00));

  assert_write_sec_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == 3'd1) |=> sc == ($past(wr_data) & 8'h7F));
endmodule

bind rtc_bcd_calendar rtc_bcd_calendar_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tick_32k(tick_32k), .wr_en(wr_en),
  .wr_addr(wr_addr), .wr_data(wr_data), .time_view(time_view),
  .hit_100(hit_100), .adv_min(adv_min), .adv_day(adv_day),
  .adv_month(adv_month), .adv_cent(adv_cent)
);

// File: tb/rtc_bcd_calendar_test.sv
module rtc_bcd_calendar_test;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 13;

  typedef struct packed {
    logic [63:0] pre;
    logic [63:0] post;
  } vec_t;

  // byte order {year, month, date, weekday, hour, min, sec, hundredths}
  localparam vec_t VECS [NVEC] = '{
    '{64'h24_03_10_02_13_45_30_99, 64'h24_03_10_02_13_45_31_00},
    '{64'h24_03_10_02_09_59_59_99, 64'h24_03_10_02_10_00_00_00},
    '{64'h24_04_30_07_23_59_59_99, 64'h24_05_01_01_00_00_00_00},
    '{64'h23_02_28_03_23_59_59_99, 64'h23_03_01_04_00_00_00_00},
    '{64'h24_02_28_03_23_59_59_99, 64'h24_02_29_04_00_00_00_00},
    '{64'h24_02_29_04_23_59_59_99, 64'h24_03_01_05_00_00_00_00},
    '{64'h25_01_31_05_23_59_59_99, 64'h25_02_01_06_00_00_00_00},
    '{64'h99_12_31_06_23_59_59_99, 64'h00_01_01_07_80_00_00_00},
    '{64'h99_12_31_01_A3_59_59_99, 64'h00_01_01_02_00_00_00_00},
    '{64'h00_02_28_01_23_59_59_99, 64'h00_02_29_02_00_00_00_00},
    '{64'h26_06_30_02_23_59_59_99, 64'h26_07_01_03_00_00_00_00},
    '{64'h26_12_31_03_23_59_59_99, 64'h27_01_01_04_00_00_00_00},
    '{64'h24_03_30_06_23_59_59_99, 64'h24_03_31_07_00_00_00_00}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_32k = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = 3'd0;
  logic [7:0]  wr_data = 8'h00;
  logic [63:0] time_view;

  int checks = 0;
  int fails = 0;

  rtc_bcd_calendar uut (
    .clk(clk), .rst_n(rst_n), .tick_32k(tick_32k), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .time_view(time_view)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic string vec_tag(int i);
    case (i)
      0, 1: return "R4";
      2: return "R5";
      3, 4, 5, 9: return "R7";
      7, 8: return "R8";
      default: return "R6";
    endcase
  endfunction

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // year first, hundredths last so the divider restarts at the end
  task automatic load(logic [63:0] v);
    for (int k = 7; k >= 0; k--) wr(3'(k), v[8*k +: 8]);
  endtask

  task automatic ticks(int n);
    @(negedge clk);
    tick_32k = 1'b1;
    repeat (n) @(negedge clk);
    tick_32k = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset view", time_view, 64'h00_01_01_01_00_00_00_00);

    repeat (40) @(negedge clk);
    check("R3 no tick holds", time_view, 64'h00_01_01_01_00_00_00_00);

    for (int i = 0; i < NVEC; i++) begin
      load(VECS[i].pre);
      check("R9 load readback", time_view, VECS[i].pre);
      ticks(327);
      check("R3 no step before 328", time_view, VECS[i].pre);
      ticks(1);
      check(vec_tag(i), time_view, VECS[i].post);
    end

    // R10: mid-count write of hundredths restarts the divider
    load(64'h24_05_05_03_08_00_10_50);
    ticks(200);
    wr(3'd0, 8'h50);
    ticks(327);
    check("R10 restart hold", time_view, 64'h24_05_05_03_08_00_10_50);
    ticks(1);
    check("R10 first step", time_view, 64'h24_05_05_03_08_00_10_51);

    // R3: exact 100 steps per 32768 pulses
    load(64'h30_05_20_03_10_20_00_00);
    ticks(32767);
    check("R3 rate 32767", time_view, 64'h30_05_20_03_10_20_00_99);
    ticks(1);
    check("R3 rate 32768", time_view, 64'h30_05_20_03_10_20_01_00);

    // R9: masking of unused bits, other bytes untouched
    wr(3'd3, 8'hD5);
    check("R9 hour mask", time_view, 64'h30_05_20_03_95_20_01_00);
    wr(3'd1, 8'hA5);
    check("R9 sec mask", time_view, 64'h30_05_20_03_95_20_25_00);
    wr(3'd5, 8'hD7);
    check("R9 date mask", time_view, 64'h30_05_17_03_95_20_25_00);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule